// File: doc/BRIEF.md
# I2C Target Address Recognition Unit

This block listens to a two-wire serial bus as a target and decides whether the first byte after a START condition selects this node. It samples the clock and data lines through synchronisers and finds START, STOP and clock edges. It then shifts in the address byte, most significant bit first. A software-writable configuration byte holds the 7-bit node address in its upper bits and a broadcast-recognition enable in its lowest bit. A received address of all zeros is the broadcast (general-call) address.

When the byte selects the node, the unit acknowledges it on its own by pulling the data line low for the ninth clock. At the end of that acknowledge clock it raises a sticky event flag and reports the kind of match. It then stretches the clock low until software clears the flag, so the bus waits for the host. An interrupt output follows the flag only while the interrupt-enable input is high. If the byte does not select the node, the data line stays released and the unit ignores the bus until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: The configuration byte resets to 0xFE, which gives a node address of 0x7F with broadcast recognition off. A one-cycle write on `cfg_we_i` replaces the whole byte, and the new value appears on `cfg_addr_o` after the next clock edge.
- R2: START is a falling data line while the clock line is high. It begins a new 8-bit capture and also restarts a capture already in progress. Bits are taken on clock rising edges, most significant bit first. STOP is a rising data line while the clock line is high, and it abandons any capture. A change on a line acts on the outputs at the second clock edge after the edge that first samples it.
- R3: An own-address match occurs when received bits 7..1 equal configuration bits 7..1, provided they are not all zero. Received bit 0 (read when 1, write when 0) is not compared.
- R4: A received address of all zeros matches only while configuration bit 0 is 1, whatever the value of received bit 0. With bit 0 cleared, such an address never matches.
- R5: On a match, `sda_oe_o` rises after the falling clock edge that ends bit 8 and falls after the falling edge that ends the ninth clock. Without a match it is never asserted, and clock pulses are ignored until the next START.
- R6: The event flag is set at the falling edge that ends the acknowledge clock. It stays set until a cycle with `flag_clr_i` high. If setting and clearing fall in the same cycle, setting wins. A clear with no flag set has no effect.
- R7: `status_o` reads 0 for no match, 1 for own address with write, 2 for own address with read and 3 for broadcast. The value is held while the flag is set, register writes do not change it, and it returns to 0 when the flag clears.
- R8: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R9: While the flag is set, `scl_oe_o` holds the clock line low and the unit ignores the bus. After the clear it is idle until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe_o | output | 1 | Pull the clock line low (stretch) |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| cfg_we_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | ADDR_W+1 | Configuration write data: address in upper bits, broadcast enable in bit 0 |
| cfg_addr_o | output | ADDR_W+1 | Current configuration byte |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one pulse that clears the event flag |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 2 | Match kind, see R7 |

## Verification
Two functions can land in the same cycle: the event flag being set at the end of the acknowledge clock, and a software clear pulse. The bench places a clear pulse on exactly the clock edge where the falling SCL, delayed by the synchronisers, sets the flag. It expects the flag to stay high with the new status, and then clears it with a separate pulse. A configuration write made while the flag is held is also checked, to confirm that it leaves the reported status alone. A behavioural model compares all outputs on every clock.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [1:0] {
        MK_NONE   = 2'd0,
        MK_OWN_WR = 2'd1,
        MK_OWN_RD = 2'd2,
        MK_GCALL  = 2'd3
    } match_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_ACK  = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

endpackage

// File: rtl/am_line_sampler.sv
module am_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl;
        logic [SYNC_STAGES-1:0] sda;
        logic                   scl_p;
        logic                   sda_p;
    } smp_t;

    localparam smp_t SMP_RST = '{scl: '1, sda: '1, scl_p: 1'b1, sda_p: 1'b1};

    smp_t smp_d, smp_q;
    logic scl_s, sda_s;

    always_comb begin
        smp_d        = smp_q;
        smp_d.scl[0] = scl_i;
        smp_d.sda[0] = sda_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            smp_d.scl[i] = smp_q.scl[i-1];
            smp_d.sda[i] = smp_q.sda[i-1];
        end
        smp_d.scl_p = smp_q.scl[LAST];
        smp_d.sda_p = smp_q.sda[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= SMP_RST;
        else        smp_q <= smp_d;
    end

    assign scl_s      = smp_q.scl[LAST];
    assign sda_s      = smp_q.sda[LAST];
    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~smp_q.scl_p;
    assign scl_fall_o = ~scl_s & smp_q.scl_p;
    assign start_o    = scl_s & smp_q.scl_p & smp_q.sda_p & ~sda_s;
    assign stop_o     = scl_s & smp_q.scl_p & ~smp_q.sda_p & sda_s;

endmodule

// File: rtl/am_addr_fsm.sv
module am_addr_fsm
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              hold_i,
    output logic              sda_oe_o,
    output logic              set_o,
    output match_kind_e       kind_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shf;
        match_kind_e         kind;
    } fsm_t;

    localparam fsm_t FSM_RST = '{phase: PH_IDLE, cnt: '0, shf: '0, kind: MK_NONE};

    fsm_t        fsm_d, fsm_q;
    match_kind_e cand;
    logic [ADDR_W-1:0] rx_addr;
    logic              rx_rd;

    assign rx_addr = fsm_q.shf[BYTE_W-1:1];
    assign rx_rd   = fsm_q.shf[0];

    always_comb begin
        if (rx_addr == '0)              cand = gc_en_i ? MK_GCALL : MK_NONE;
        else if (rx_addr == own_addr_i) cand = rx_rd ? MK_OWN_RD : MK_OWN_WR;
        else                            cand = MK_NONE;
    end

    always_comb begin
        fsm_d = fsm_q;
        set_o = 1'b0;
        unique case (fsm_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    fsm_d.phase = PH_ADDR;
                    fsm_d.cnt   = '0;
                end
            end
            PH_ADDR: begin
                if (stop_i) begin
                    fsm_d.phase = PH_IDLE;
                end else if (start_i) begin
                    fsm_d.cnt = '0;
                end else if (scl_rise_i && fsm_q.cnt < CNT_FULL) begin
                    fsm_d.shf = {fsm_q.shf[BYTE_W-2:0], sda_s_i};
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end else if (scl_fall_i && fsm_q.cnt == CNT_FULL) begin
                    fsm_d.kind  = cand;
                    fsm_d.phase = (cand != MK_NONE) ? PH_ACK : PH_IDLE;
                end
            end
            PH_ACK: begin
                if (stop_i) begin
                    fsm_d.phase = PH_IDLE;
                end else if (start_i) begin
                    fsm_d.phase = PH_ADDR;
                    fsm_d.cnt   = '0;
                end else if (scl_fall_i) begin
                    set_o       = 1'b1;
                    fsm_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (!hold_i) fsm_d.phase = PH_IDLE;
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign sda_oe_o = (fsm_q.phase == PH_ACK);
    assign kind_o   = fsm_q.kind;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.cnt <= CNT_FULL);

    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fsm_q.phase != PH_HOLD) |=> (fsm_q.phase == PH_ADDR && fsm_q.cnt == '0));

    p_stop_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && (fsm_q.phase == PH_ADDR || fsm_q.phase == PH_ACK)) |=> fsm_q.phase == PH_IDLE);

    p_ack_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> kind_o != MK_NONE);

endmodule

// File: rtl/am_event_flag.sv
module am_event_flag
    import i2c_am_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_i,
    input  match_kind_e kind_i,
    input  logic        clr_i,
    output logic        flag_o,
    output match_kind_e status_o
);
    typedef struct packed {
        logic        flag;
        match_kind_e status;
    } evt_t;

    localparam evt_t EVT_RST = '{flag: 1'b0, status: MK_NONE};

    evt_t evt_d, evt_q;

    always_comb begin
        evt_d = evt_q;
        if (set_i) begin
            evt_d.flag   = 1'b1;
            evt_d.status = kind_i;
        end else if (clr_i) begin
            evt_d.flag   = 1'b0;
            evt_d.status = MK_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= EVT_RST;
        else        evt_q <= evt_d;
    end

    assign flag_o   = evt_q.flag;
    assign status_o = evt_q.status;

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i && !set_i) |=> (flag_o && $stable(status_o)));

    p_status_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> status_o == MK_NONE);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            scl_oe_o,
    output logic            sda_oe_o,
    input  logic            cfg_we_i,
    input  logic [ADDR_W:0] cfg_wdata_i,
    output logic [ADDR_W:0] cfg_addr_o,
    input  logic            irq_en_i,
    input  logic            flag_clr_i,
    output logic            flag_o,
    output logic            irq_o,
    output logic [1:0]      status_o
);
    localparam int REG_W = ADDR_W + 1;
    localparam logic [REG_W-1:0] CFG_RST = {{ADDR_W{1'b1}}, 1'b0};

    logic [REG_W-1:0] cfg_d, cfg_q;
    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic ev_set, flag;
    match_kind_e ev_kind, status;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) cfg_d = cfg_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    am_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    am_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .own_addr_i (cfg_q[REG_W-1:1]),
        .gc_en_i    (cfg_q[0]),
        .hold_i     (flag),
        .sda_oe_o   (sda_oe_o),
        .set_o      (ev_set),
        .kind_o     (ev_kind)
    );

    am_event_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_set),
        .kind_i   (ev_kind),
        .clr_i    (flag_clr_i),
        .flag_o   (flag),
        .status_o (status)
    );

    assign cfg_addr_o = cfg_q;
    assign flag_o     = flag;
    assign scl_oe_o   = flag;
    assign irq_o      = flag & irq_en_i;
    assign status_o   = status;

    p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> cfg_addr_o == $past(cfg_wdata_i));

    p_no_ack_while_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> !sda_oe_o);

endmodule

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wd = 8'h00;
    logic [7:0] cfg_addr;
    logic       irq_en = 1'b0, flag_clr = 1'b0;
    logic       flag, irq;
    logic [1:0] status;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .cfg_we_i(cfg_we),
        .cfg_wdata_i(cfg_wd), .cfg_addr_o(cfg_addr), .irq_en_i(irq_en),
        .flag_clr_i(flag_clr), .flag_o(flag), .irq_o(irq), .status_o(status)
    );

    int n_vec = 0, n_bad = 0;
    bit run_cmp = 0, done = 0;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 address, 2 acknowledge, 3 held
    int ms, mcnt, msh, mk, mst, maddr;
    bit mf;
    bit hs[$];
    bit hd[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            hs = '{1, 1, 1, 1};
            hd = '{1, 1, 1, 1};
            ms = 0; mcnt = 0; msh = 0; mk = 0; mst = 0; mf = 0; maddr = 'hFE;
        end else begin
            bit ls, ld, cs, os, cd, od, rise, fall, st, sp, setv;
            int a;
            ls = m_scl & ~mf;
            ld = m_sda & ~(ms == 2);
            hs.push_front(ls); void'(hs.pop_back());
            hd.push_front(ld); void'(hd.pop_back());
            cs = hs[2]; os = hs[3]; cd = hd[2]; od = hd[3];
            rise = cs & ~os;
            fall = ~cs & os;
            st   = cs & os & od & ~cd;
            sp   = cs & os & ~od & cd;
            setv = 0;
            case (ms)
                0: if (st) begin ms = 1; mcnt = 0; end
                1: begin
                    if (sp) ms = 0;
                    else if (st) mcnt = 0;
                    else if (rise && mcnt < 8) begin
                        msh = ((msh << 1) | int'(cd)) & 255;
                        mcnt++;
                    end else if (fall && mcnt == 8) begin
                        a = msh >> 1;
                        if (a == 0) mk = (maddr % 2 == 1) ? 3 : 0;
                        else if (a == (maddr >> 1)) mk = (msh % 2 == 1) ? 2 : 1;
                        else mk = 0;
                        ms = (mk != 0) ? 2 : 0;
                    end
                end
                2: begin
                    if (sp) ms = 0;
                    else if (st) begin ms = 1; mcnt = 0; end
                    else if (fall) begin setv = 1; ms = 3; end
                end
                default: if (!mf) ms = 0;
            endcase
            if (setv) begin mf = 1; mst = mk; end
            else if (flag_clr) begin mf = 0; mst = 0; end
            if (cfg_we) maddr = cfg_wd;
        end
    end

    always @(negedge clk) begin
        if (run_cmp && !done) begin
            chk("R5 sda_oe vs model", sda_oe, int'(ms == 2));
            chk("R9 scl_oe vs model", scl_oe, int'(mf));
            chk("R6 flag vs model", flag, int'(mf));
            chk("R8 irq vs model", irq, int'(mf && irq_en));
            chk("R7 status vs model", status, mst);
            chk("R1 cfg vs model", cfg_addr, maddr);
        end
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; wt(2); m_scl = 1; wt(6); m_sda = 0; wt(6); m_scl = 0; wt(4);
    endtask

    task automatic bus_stop();
        m_sda = 0; wt(4); m_scl = 1; wt(6); m_sda = 1; wt(6);
    endtask

    task automatic bus_bit(bit b);
        m_sda = b; wt(4); m_scl = 1; wt(8); m_scl = 0; wt(4);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    endtask

    task automatic ack_slot(bit exp_ack, string tag);
        m_sda = 1; wt(4); m_scl = 1; wt(4);
        chk(tag, sda_line, int'(!exp_ack));
        wt(4); m_scl = 0; wt(6);
    endtask

    task automatic address(logic [7:0] b, bit exp_ack, string tag);
        bus_start(); send_byte(b); ack_slot(exp_ack, tag);
    endtask

    task automatic clear_flag();
        flag_clr = 1; wt(1); flag_clr = 0; wt(3);
    endtask

    task automatic write_cfg(logic [7:0] v);
        cfg_we = 1; cfg_wd = v; wt(1); cfg_we = 0; wt(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        wt(5); rst_n = 1; run_cmp = 1; wt(2);
        chk("R1 reset cfg value", cfg_addr, 'hFE);
        chk("R6 reset flag", flag, 0);
        chk("R7 reset status", status, 0);
        chk("R9 reset scl_oe", scl_oe, 0);

        // default address 0x7F, write
        irq_en = 1;
        address(8'hFE, 1, "R5 ack for default address");
        wt(2);
        chk("R3 flag after own match", flag, 1);
        chk("R7 status own write", status, 1);
        chk("R8 irq with enable", irq, 1);
        chk("R9 scl held", scl_oe, 1);
        // bus activity while held is ignored
        m_scl = 1; wt(4);
        chk("R9 clock line held low", scl_line, 0);
        m_sda = 0; wt(6); m_sda = 1; wt(6);
        chk("R9 status kept while held", status, 1);
        chk("R9 flag kept while held", flag, 1);
        irq_en = 0; wt(1);
        chk("R8 irq masked", irq, 0);
        irq_en = 1;
        write_cfg(8'hA4);
        chk("R7 status unchanged by cfg write", status, 1);
        chk("R1 cfg written", cfg_addr, 'hA4);
        m_scl = 0; wt(2);
        clear_flag();
        chk("R6 flag cleared", flag, 0);
        chk("R7 status after clear", status, 0);
        chk("R9 scl released", scl_oe, 0);
        bus_stop();
        clear_flag();
        chk("R6 clear without flag", flag, 0);

        // own address 0x52, read
        address(8'hA5, 1, "R3 ack own read");
        wt(2);
        chk("R7 status own read", status, 2);
        clear_flag(); bus_stop();

        // zero address with broadcast off
        address(8'h00, 0, "R4 no ack broadcast disabled");
        chk("R4 no flag broadcast disabled", flag, 0);
        bus_stop();

        // other address, then own address bits without START
        address(8'hA6, 0, "R3 no ack other address");
        send_byte(8'hA4);
        ack_slot(0, "R5 ignored until START");
        chk("R5 no flag without START", flag, 0);
        bus_stop();

        // broadcast enabled
        write_cfg(8'hA5);
        address(8'h00, 1, "R4 ack broadcast write");
        wt(2);
        chk("R4 status broadcast", status, 3);
        clear_flag(); bus_stop();
        address(8'h01, 1, "R4 ack broadcast read bit");
        wt(2);
        chk("R4 status broadcast read bit", status, 3);
        clear_flag(); bus_stop();

        // STOP abandons a capture
        bus_start();
        bus_bit(1); bus_bit(0); bus_bit(1); bus_bit(0);
        bus_stop();
        m_scl = 0; wt(4);
        bus_bit(0); bus_bit(1); bus_bit(0); bus_bit(0);
        ack_slot(0, "R2 stop abandons capture");
        chk("R2 no flag after stop", flag, 0);
        bus_stop();

        // repeated START restarts capture
        bus_start();
        bus_bit(1); bus_bit(1); bus_bit(1);
        bus_start();
        send_byte(8'hA4);
        ack_slot(1, "R2 repeated start");
        wt(2);
        chk("R2 status after repeated start", status, 1);
        clear_flag(); bus_stop();

        // set and clear in the same cycle
        bus_start();
        send_byte(8'hA5);
        m_sda = 1; wt(4); m_scl = 1; wt(8); m_scl = 0;
        wt(2); flag_clr = 1; wt(1); flag_clr = 0;
        chk("R6 set wins over clear", flag, 1);
        chk("R7 status after collision", status, 2);
        wt(4);
        clear_flag();
        chk("R6 clear after collision", flag, 0);
        bus_stop();

        wt(10);
        finish_up();
    end
endmodule